// File: doc/BRIEF.md
# Multi-Scheme DSSS Chip Modulator

This block is the spreading modulator on the transmit side of a direct-sequence spread spectrum transceiver. Each symbol period it takes one data bit per channel. Each chip period it takes spreading chips from an external code source. It combines the two and maps the result onto signed in-phase (I) and quadrature (Q) baseband samples at two samples per chip. Pulse shaping, carrier upconversion and code generation are done by neighbouring blocks.

The block runs either as four independent BPSK spread channels or as two quadrature channels. A quadrature channel can use plain BPSK, QPSK, offset QPSK, quadri-phase PN (a separate code on each branch) or offset QPN. In the offset schemes the Q branch lags the I branch by half a chip. A differential option encodes every data bit against the previous encoded bit before spreading. The I branch and the Q branch each have their own 8-bit gain, which sets the transmit level over roughly a 20 dB range (gain 255 down to about 25).

The upstream pacing logic drives three strobes. `samp_stb_i` marks every output sample. `chip_stb_i` marks the first sample of each chip. `sym_stb_i` marks the first sample of each symbol. The scheme, the channel mode and the differential setting take effect only at a symbol strobe.

Top module: `dsss_chip_mod`

## Requirements
- R1: After reset, `valid_o` is low, all I/Q lane outputs are 0 and the differential state of every data bit is 0.
- R2: `valid_o` is high in the cycle after a `samp_stb_i` cycle and low otherwise. Lane outputs update only one cycle after a sample strobe and otherwise hold their value.
- R3: A spread bit of 0 produces +gain and a spread bit of 1 produces -gain, as a 10-bit two's-complement lane value. The spread bit is data XOR chip, and the gain is unsigned 8-bit.
- R4: With the mode bit at 0 (four-channel), lane n (n = 0..3) carries I from data[n] XOR code_i[n], its Q output is 0, and the scheme code is ignored.
- R5: With the mode bit at 1 (two-channel), lane k (k = 0,1) takes its I bit from data[2k] and its Q bit from data[2k+1], and lanes 2 and 3 output 0 on both branches.
- R6: Scheme codes in two-channel mode are 0 = BPSK (Q is 0), 1 = QPSK, 2 = OQPSK, 3 = QPN and 4 = OQPN; any other code acts as BPSK. QPSK and OQPSK spread Q with code_i[k]. QPN and OQPN spread Q with code_q[k].
- R7: In OQPSK and OQPN the Q output at each sample is the Q value the lane computed at the previous sample, which is a half-chip lag at two samples per chip. After reset that previous value is 0.
- R8: With differential enabled at a symbol strobe, the stored bit for each data lane becomes data XOR its previous stored bit. With differential disabled it becomes the raw data bit.
- R9: The mode, scheme and differential inputs are used only in a `sym_stb_i` cycle; in any other cycle they have no effect on the outputs.
- R10: Data bits are taken only with `sym_stb_i`, and code chips only with `chip_stb_i`. Between strobes the stored values are used.
- R11: The I and Q gains are independent and are applied at every sample strobe without waiting for a symbol boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samp_stb_i | input | 1 | Output sample strobe |
| chip_stb_i | input | 1 | First sample of a chip; code inputs valid |
| sym_stb_i | input | 1 | First sample of a symbol; data and config valid |
| data_i | input | 4 | Symbol data bit per data lane |
| code_i_i | input | 4 | I-branch chip per lane |
| code_q_i | input | 4 | Q-branch chip per lane (QPN/OQPN) |
| quad_mode_i | input | 1 | 0: four BPSK channels, 1: two quadrature channels |
| scheme_i | input | 3 | Chip modulation scheme code |
| diff_en_i | input | 1 | Differential encoding enable |
| gain_i_i | input | 8 | I-branch amplitude |
| gain_q_i | input | 8 | Q-branch amplitude |
| valid_o | output | 1 | Sample output valid |
| samp_i_o | output | 40 | Four 10-bit signed I samples, lane k at bits 10k+9:10k |
| samp_q_o | output | 40 | Four 10-bit signed Q samples, lane k at bits 10k+9:10k |

## Verification
The bench switches into offset QPN on a symbol whose Q value differs from the last one. The first offset sample must still show the old Q value, and the new value must appear one sample later. A design with no delay, or with a full-chip delay, shows the new value too early or too late. It changes mode and scheme inputs at a chip strobe that is not a symbol strobe. A design that reads them live would light up lanes 2 and 3 or lose the offset. It drives a three-symbol differential sequence after reset, where a missing XOR or a state that starts at the wrong value flips lane signs. Gains of 255 and 1 expose sign-extension errors, which turn -255 into a positive number.

// File: rtl/dsss_mod_pkg.sv
package dsss_mod_pkg;
  typedef enum logic [2:0] {
    SCH_BPSK  = 3'd0,
    SCH_QPSK  = 3'd1,
    SCH_OQPSK = 3'd2,
    SCH_QPN   = 3'd3,
    SCH_OQPN  = 3'd4
  } scheme_e;

  typedef struct packed {
    logic    quad;
    scheme_e sch;
    logic    diff;
  } mod_cfg_t;
endpackage

// File: rtl/dsss_sym_reg.sv
module dsss_sym_reg
  import dsss_mod_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_stb_i,
  input  logic [NUM_CH-1:0] data_i,
  input  logic              quad_i,
  input  logic [2:0]        scheme_i,
  input  logic              diff_i,
  output logic [NUM_CH-1:0] data_o,
  output mod_cfg_t          cfg_o
);
  logic [NUM_CH-1:0] data_q;
  mod_cfg_t          cfg_q, cfg_new;
  logic [NUM_CH-1:0] data_new;

  always_comb begin
    cfg_new.quad = quad_i;
    cfg_new.sch  = scheme_e'(scheme_i);
    cfg_new.diff = diff_i;
    data_new     = diff_i ? (data_i ^ data_q) : data_i;
  end

  // new symbol is visible in the same sample it arrives with
  assign data_o = sym_stb_i ? data_new : data_q;
  assign cfg_o  = sym_stb_i ? cfg_new  : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else if (sym_stb_i) begin
      data_q <= data_new;
      cfg_q  <= cfg_new;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> $stable(data_q)); // R10
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_stb_i |=> $stable(cfg_q)); // R9
endmodule

// File: rtl/dsss_chip_reg.sv
module dsss_chip_reg #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_stb_i,
  input  logic [NUM_CH-1:0] ci_i,
  input  logic [NUM_CH-1:0] cq_i,
  output logic [NUM_CH-1:0] ci_o,
  output logic [NUM_CH-1:0] cq_o
);
  logic [NUM_CH-1:0] ci_q, cq_q;

  assign ci_o = chip_stb_i ? ci_i : ci_q;
  assign cq_o = chip_stb_i ? cq_i : cq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ci_q <= '0;
      cq_q <= '0;
    end else if (chip_stb_i) begin
      ci_q <= ci_i;
      cq_q <= cq_i;
    end
  end

  AST_CHIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_stb_i |=> ($stable(ci_q) && $stable(cq_q))); // R10
endmodule

// File: rtl/dsss_lane.sv
module dsss_lane
  import dsss_mod_pkg::*;
#(
  parameter int LANE   = 0,
  parameter int NUM_CH = 4,
  parameter int GAIN_W = 8,
  parameter int OUT_W  = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    samp_stb_i,
  input  logic                    quad_i,
  input  scheme_e                 sch_i,
  input  logic                    bd_i,   // data bit, four-channel mode
  input  logic                    qdi_i,  // I data bit, quad mode
  input  logic                    qdq_i,  // Q data bit, quad mode
  input  logic                    ci_i,
  input  logic                    cq_i,
  input  logic [GAIN_W-1:0]       gain_i_i,
  input  logic [GAIN_W-1:0]       gain_q_i,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o
);
  localparam int  HALF    = NUM_CH / 2;
  localparam bit  QUAD_OK = (LANE < HALF);
  localparam int  PAD     = OUT_W - GAIN_W;

  logic signed [OUT_W-1:0] gi_pos, gq_pos, i_val, q_raw, q_val, q_dly;
  logic i_on, q_on, q_off, i_bit, q_bit;

  assign gi_pos = $signed({{PAD{1'b0}}, gain_i_i});
  assign gq_pos = $signed({{PAD{1'b0}}, gain_q_i});

  always_comb begin
    i_on  = 1'b0;
    q_on  = 1'b0;
    q_off = 1'b0;
    i_bit = 1'b0;
    q_bit = 1'b0;
    if (!quad_i) begin
      i_on  = 1'b1;
      i_bit = bd_i ^ ci_i;
    end else if (QUAD_OK) begin
      i_on  = 1'b1;
      i_bit = qdi_i ^ ci_i;
      unique case (sch_i)
        SCH_QPSK, SCH_OQPSK: begin
          q_on  = 1'b1;
          q_bit = qdq_i ^ ci_i;
        end
        SCH_QPN, SCH_OQPN: begin
          q_on  = 1'b1;
          q_bit = qdq_i ^ cq_i;
        end
        default: q_on = 1'b0;
      endcase
      q_off = (sch_i == SCH_OQPSK) || (sch_i == SCH_OQPN);
    end
  end

  assign i_val = !i_on ? '0 : (i_bit ? -gi_pos : gi_pos);
  assign q_raw = !q_on ? '0 : (q_bit ? -gq_pos : gq_pos);
  assign q_val = q_off ? q_dly : q_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o   <= '0;
      q_o   <= '0;
      q_dly <= '0;
    end else if (samp_stb_i) begin
      i_o   <= i_val;
      q_o   <= q_val;
      q_dly <= q_raw;
    end
  end

  AST_BPSK4_Q_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_stb_i && !quad_i) |=> (q_o == '0)); // R4
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_stb_i && quad_i && !QUAD_OK) |=> (i_o == '0 && q_o == '0)); // R5
  AST_I_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_stb_i && (!quad_i || QUAD_OK)) |=>
      (i_o == $past(gi_pos) || i_o == -$past(gi_pos))); // R3
  AST_OFFSET_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_stb_i && quad_i && QUAD_OK && (sch_i == SCH_OQPN || sch_i == SCH_OQPSK))
      |=> (q_o == $past(q_dly))); // R7
endmodule

// File: rtl/dsss_chip_mod.sv
module dsss_chip_mod
  import dsss_mod_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int GAIN_W = 8,
  parameter int OUT_W  = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     samp_stb_i,
  input  logic                     chip_stb_i,
  input  logic                     sym_stb_i,
  input  logic [NUM_CH-1:0]        data_i,
  input  logic [NUM_CH-1:0]        code_i_i,
  input  logic [NUM_CH-1:0]        code_q_i,
  input  logic                     quad_mode_i,
  input  logic [2:0]               scheme_i,
  input  logic                     diff_en_i,
  input  logic [GAIN_W-1:0]        gain_i_i,
  input  logic [GAIN_W-1:0]        gain_q_i,
  output logic                     valid_o,
  output logic [NUM_CH*OUT_W-1:0]  samp_i_o,
  output logic [NUM_CH*OUT_W-1:0]  samp_q_o
);
  localparam int HALF = NUM_CH / 2;

  logic [NUM_CH-1:0] data_eff, ci_eff, cq_eff;
  mod_cfg_t          cfg_eff;

  dsss_sym_reg #(.NUM_CH(NUM_CH)) u_sym (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sym_stb_i(sym_stb_i),
    .data_i   (data_i),
    .quad_i   (quad_mode_i),
    .scheme_i (scheme_i),
    .diff_i   (diff_en_i),
    .data_o   (data_eff),
    .cfg_o    (cfg_eff)
  );

  dsss_chip_reg #(.NUM_CH(NUM_CH)) u_chip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_stb_i(chip_stb_i),
    .ci_i      (code_i_i),
    .cq_i      (code_q_i),
    .ci_o      (ci_eff),
    .cq_o      (cq_eff)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    logic qdi, qdq;
    logic signed [OUT_W-1:0] li, lq;
    if (k < HALF) begin : g_quad
      assign qdi = data_eff[2*k];
      assign qdq = data_eff[2*k+1];
    end else begin : g_single
      assign qdi = 1'b0;
      assign qdq = 1'b0;
    end
    dsss_lane #(.LANE(k), .NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .samp_stb_i(samp_stb_i),
      .quad_i    (cfg_eff.quad),
      .sch_i     (cfg_eff.sch),
      .bd_i      (data_eff[k]),
      .qdi_i     (qdi),
      .qdq_i     (qdq),
      .ci_i      (ci_eff[k]),
      .cq_i      (cq_eff[k]),
      .gain_i_i  (gain_i_i),
      .gain_q_i  (gain_q_i),
      .i_o       (li),
      .q_o       (lq)
    );
    assign samp_i_o[k*OUT_W +: OUT_W] = li;
    assign samp_q_o[k*OUT_W +: OUT_W] = lq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= samp_stb_i;
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_stb_i |=> ($stable(samp_i_o) && $stable(samp_q_o) && !valid_o)); // R2
endmodule

// File: tb/dsss_chip_mod_tb.sv
module dsss_chip_mod_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_stb = 1'b0, chip_stb = 1'b0, sym_stb = 1'b0;
  logic [3:0] data = '0, ci = '0, cq = '0;
  logic       quad = 1'b0, diff = 1'b0;
  logic [2:0] sch = '0;
  logic [7:0] gi = 8'd100, gq = 8'd50;
  logic       valid;
  logic [39:0] si, sq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dsss_chip_mod u_dut (
    .clk_i(clk), .rst_ni(rst_n), .samp_stb_i(samp_stb), .chip_stb_i(chip_stb),
    .sym_stb_i(sym_stb), .data_i(data), .code_i_i(ci), .code_q_i(cq),
    .quad_mode_i(quad), .scheme_i(sch), .diff_en_i(diff), .gain_i_i(gi),
    .gain_q_i(gq), .valid_o(valid), .samp_i_o(si), .samp_q_o(sq)
  );

  function automatic int lane_i(int k);
    return int'($signed(si[k*10 +: 10]));
  endfunction
  function automatic int lane_q(int k);
    return int'($signed(sq[k*10 +: 10]));
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_lanes(string req, int ei[4], int eq[4]);
    for (int k = 0; k < 4; k++) begin
      chk(req, $sformatf("lane%0d I", k), lane_i(k), ei[k]);
      chk(req, $sformatf("lane%0d Q", k), lane_q(k), eq[k]);
    end
  endtask

  // one sample: drive at negedge, DUT registers at posedge, check at next negedge
  task automatic sample(bit sy, bit ch);
    samp_stb = 1'b1; sym_stb = sy; chip_stb = ch;
    @(negedge clk);
    samp_stb = 1'b0; sym_stb = 1'b0; chip_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "valid", int'(valid), 0);
    chk_lanes("R1", '{0,0,0,0}, '{0,0,0,0});
  endtask

  task automatic t_bpsk4();
    quad = 0; sch = 3'd3; diff = 0; gi = 100; gq = 50;
    data = 4'b0101; ci = 4'b0011;
    sample(1, 1);
    chk("R2", "valid", int'(valid), 1);
    chk_lanes("R4", '{100,-100,-100,100}, '{0,0,0,0});
    // R10: new code and data without strobes are ignored
    data = 4'b1111; ci = 4'b1111;
    sample(0, 0);
    chk_lanes("R10", '{100,-100,-100,100}, '{0,0,0,0});
  endtask

  task automatic t_quad();
    quad = 1; sch = 3'd1; data = 4'b1001; ci = 4'b0001; cq = 4'b0010;
    sample(1, 1);
    chk_lanes("R6", '{100,100,0,0}, '{-50,-50,0,0});
    chk("R5", "lane2 I", lane_i(2), 0);
    sch = 3'd3;
    sample(1, 1);
    chk_lanes("R6", '{100,100,0,0}, '{50,50,0,0});
    sch = 3'd0;
    sample(1, 1);
    chk_lanes("R6", '{100,100,0,0}, '{0,0,0,0});
    sch = 3'd3;
    sample(1, 1);
    chk("R6", "lane0 Q back in QPN", lane_q(0), 50);
  endtask

  task automatic t_offset();
    sch = 3'd4; data = 4'b0000; ci = 4'b0000; cq = 4'b0011;
    sample(1, 1);   // raw Q -50, shown Q is previous +50
    chk_lanes("R7", '{100,100,0,0}, '{50,50,0,0});
    sample(0, 0);
    chk("R7", "lane0 Q half chip later", lane_q(0), -50);
    cq = 4'b0000;
    sample(0, 1);   // raw +50, shown -50
    chk("R7", "lane1 Q lag", lane_q(1), -50);
    sample(0, 0);
    chk("R7", "lane1 Q settles", lane_q(1), 50);
    // R9: mode/scheme changes off a symbol strobe are ignored
    quad = 0; sch = 3'd0; cq = 4'b0011;
    sample(0, 1);
    chk("R9", "lane2 I stays off", lane_i(2), 0);
    chk("R9", "lane0 Q still offset", lane_q(0), 50);
    sample(0, 0);
    chk("R9", "lane0 Q follows lag", lane_q(0), -50);
  endtask

  task automatic t_diff();
    do_reset();
    quad = 0; diff = 1; ci = 4'b0000; gi = 100;
    data = 4'b0011;
    sample(1, 1);
    chk_lanes("R8", '{-100,-100,100,100}, '{0,0,0,0});
    data = 4'b0110;
    sample(1, 1);
    chk_lanes("R8", '{-100,100,-100,100}, '{0,0,0,0});
    data = 4'b0000;
    sample(1, 1);
    chk_lanes("R8", '{-100,100,-100,100}, '{0,0,0,0});
    diff = 0;
  endtask

  task automatic t_gain();
    do_reset();
    quad = 0; sch = 3'd0; data = 4'b0001; ci = 4'b0000; gi = 255; gq = 0;
    sample(1, 1);
    chk("R3", "lane0 -255", lane_i(0), -255);
    chk("R3", "lane1 +255", lane_i(1), 255);
    gi = 1; gq = 255; quad = 1; sch = 3'd1; data = 4'b0010;
    sample(1, 1);
    chk("R11", "lane0 I gain 1", lane_i(0), 1);
    chk("R11", "lane0 Q gain 255", lane_q(0), -255);
    gi = 7;   // no symbol strobe: gain still applies
    sample(0, 0);
    chk("R11", "lane0 I new gain", lane_i(0), 7);
  endtask

  task automatic t_idle();
    gi = 200;
    @(negedge clk);
    chk("R2", "valid low when idle", int'(valid), 0);
    chk("R2", "lane0 I held", lane_i(0), 7);
  endtask

  initial begin
    t_reset();
    t_bpsk4();
    t_quad();
    t_offset();
    t_diff();
    t_gain();
    t_idle();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule